// File: doc/BRIEF.md
# Serial EEPROM Boot Reader

This block is a two-wire serial-bus master that pulls configuration bytes out of an external serial EEPROM. Every transfer is a random-address read. It opens with a start condition and sends the device address with the write direction bit. It then sends the word address, issues a repeated start, and sends the device address again with the read direction bit. After that it clocks in either one byte or four consecutive bytes and closes the bus with a stop. The clock line is always driven by the block. The data line works open-drain: `sda_oe` pulls it low, and the line level comes back on `sda_i`.

After reset is released, the block checks that both bus lines sit high. If they do, it starts a four-byte load from a fixed boot word address with no host action. If either line is low, it reports that no device is present and stays idle. Afterwards a host can request further reads by giving a word address, a width select and a one-cycle go pulse. It then waits for the done flag and reads the data and the error flag.

Bus timing comes from a programmable divider. One bit period is four quarter-periods of `QTR_DIV` clocks each.

Top module: `eeprom_boot_reader`

## Requirements
- R1: When reset is released with `scl_i` and `sda_i` both high, the block on its own reads four bytes starting at word address `BOOT_ADDR` (default 0x00) and then raises `done` with the data on `rd_data`.
- R2: When either line is low as reset is released, `no_dev` goes to 1, `busy` goes to 0, and no transfer happens: `scl_o` stays 1 and `sda_oe` stays 0.
- R3: Each transfer sends, in this order: a start, the byte 0xA0 (device address 1010000 followed by direction bit 0), the 8-bit word address, a repeated start, the byte 0xA1 (direction bit 1), and then the data bytes. Every byte is sent and received most significant bit first.
- R4: With `req_dword`=0, one byte is read and `rd_data` = {24'h0, byte}.
- R5: With `req_dword`=1, four bytes are read from consecutive word addresses. The first byte received lands in `rd_data[31:24]` and the last in `rd_data[7:0]`.
- R6: After every received byte except the last, the master drives an acknowledge (SDA low). After the last byte it leaves SDA high (not-acknowledge) and then issues a stop.
- R7: If SDA is high in any of the three slave acknowledge slots, the block ends the transfer with a stop and sets both `done` and `err` to 1.
- R8: SDA changes only while SCL is low. The only exceptions are a start (SDA falls while SCL is high) and a stop (SDA rises while SCL is high). `scl_o` and `sda_oe` never change at the same clock edge.
- R9: `req_go` is ignored while `busy` is 1.
- R10: During a transfer, every SCL high pulse lasts exactly 2*`QTR_DIV` clocks.
- R11: `busy` is 1 from the cycle after an accepted request until the stop completes. `done` and `err` are cleared when a request is accepted and otherwise hold their value. When idle, `scl_o` is 1 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_o | output | 1 | Serial clock driven to the bus |
| scl_i | input | 1 | Serial clock level read back from the bus (presence check) |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Data line level |
| req_addr | input | 8 | Word address of a host request |
| req_dword | input | 1 | 1 reads four bytes, 0 reads one byte |
| req_go | input | 1 | One-cycle request pulse, taken when idle |
| rd_data | output | 32 | Collected data, valid when done is 1 and err is 0 |
| done | output | 1 | Last transfer finished |
| err | output | 1 | Last transfer aborted on a missing slave acknowledge |
| no_dev | output | 1 | Bus lines were low at reset release |
| busy | output | 1 | Transfer or boot check in progress |

## Verification
The bench attaches an EEPROM model whose byte at each address is a computed scramble of that address. With that model, a wrong word address, a dropped byte or a byte out of order shows up as a different value. Reads are tried as single bytes and as doublewords, including a doubleword that wraps the word address from 0xFF to 0x00, which separates correct address increment from fixed or truncated addressing. The model refuses an acknowledge in each of the three address slots in turn, to show that the abort works in every phase. A request pulsed mid-transfer and a reset with the clock line held low cover the paths where the block must not act.

// File: rtl/eeb_pkg.sv
`timescale 1ns/1ps
package eeb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] EE_DEV = 7'b1010000;

  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WR, BC_RD} bitcmd_e;

  typedef enum logic [3:0] {
    SQ_BOOT, SQ_IDLE, SQ_START, SQ_TX, SQ_SACK,
    SQ_RSTART, SQ_RX, SQ_MACK, SQ_STOP
  } seq_e;

  typedef enum logic [1:0] {PH_DEVW, PH_WORD, PH_DEVR} txsel_e;
endpackage

// File: rtl/eeb_clkdiv.sv
`timescale 1ns/1ps
module eeb_clkdiv #(
  parameter int QTR_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(QTR_DIV - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= wrap;
    end
  end
endmodule

// File: rtl/eeb_bitphy.sv
`timescale 1ns/1ps
module eeb_bitphy
  import eeb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    go,
  input  bitcmd_e cmd,
  input  logic    wbit,
  input  logic    sda_in,
  output logic    busy,
  output logic    done,
  output logic    rbit,
  output logic    scl_o,
  output logic    sda_oe
);
  bitcmd_e    cmd_q, cmd_d;
  logic       busy_d, wb_q, wb_d;
  logic [1:0] ph_q, ph_d;
  logic       scl_d, oe_d, rb_d, dn_d;
  logic       lvl_scl, lvl_oe;

  // line levels for the current quarter of the current bit command
  always_comb begin
    lvl_scl = (ph_q == 2'd1) || (ph_q == 2'd2);
    lvl_oe  = 1'b0;
    unique case (cmd_q)
      BC_START: lvl_oe = ph_q[1];
      BC_STOP: begin
        lvl_scl = (ph_q != 2'd0);
        lvl_oe  = !ph_q[1];
      end
      BC_WR:   lvl_oe = !wb_q;
      default: lvl_oe = 1'b0;
    endcase
  end

  always_comb begin
    busy_d = busy;
    cmd_d  = cmd_q;
    wb_d   = wb_q;
    ph_d   = ph_q;
    scl_d  = scl_o;
    oe_d   = sda_oe;
    rb_d   = rbit;
    dn_d   = 1'b0;
    if (!busy) begin
      if (go) begin
        busy_d = 1'b1;
        cmd_d  = cmd;
        wb_d   = wbit;
        ph_d   = 2'd0;
      end
    end else if (tick) begin
      scl_d = lvl_scl;
      oe_d  = lvl_oe;
      ph_d  = ph_q + 2'd1;
      if (cmd_q == BC_RD && ph_q == 2'd2) rb_d = sda_in;
      if (ph_q == 2'd3) begin
        busy_d = 1'b0;
        dn_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmd_q  <= BC_STOP;
      wb_q   <= 1'b1;
      ph_q   <= 2'd0;
      scl_o  <= 1'b1;
      sda_oe <= 1'b0;
      rbit   <= 1'b1;
      done   <= 1'b0;
    end else begin
      busy   <= busy_d;
      cmd_q  <= cmd_d;
      wb_q   <= wb_d;
      ph_q   <= ph_d;
      scl_o  <= scl_d;
      sda_oe <= oe_d;
      rbit   <= rb_d;
      done   <= dn_d;
    end
  end
endmodule

// File: rtl/eeb_seq.sv
`timescale 1ns/1ps
module eeb_seq
  import eeb_pkg::*;
#(
  parameter logic [7:0] BOOT_ADDR   = 8'h00,
  parameter int         BOOT_SETTLE = 3,
  parameter int         WIDE_BYTES  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_ok,
  input  logic [BYTE_W-1:0]              req_addr,
  input  logic                           req_dword,
  input  logic                           req_go,
  input  logic                           phy_busy,
  input  logic                           phy_done,
  input  logic                           phy_rbit,
  output logic                           phy_go,
  output bitcmd_e                        phy_cmd,
  output logic                           phy_wbit,
  output logic [BYTE_W*WIDE_BYTES-1:0]   rd_data,
  output logic                           done,
  output logic                           err,
  output logic                           no_dev,
  output logic                           busy
);
  localparam int DW = BYTE_W * WIDE_BYTES;
  localparam int LW = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1;
  localparam int SW = $clog2(BOOT_SETTLE + 1);

  seq_e              st_q, st_d;
  txsel_e            sel_q, sel_d;
  logic [2:0]        bitn_q, bitn_d;
  logic [LW-1:0]     left_q, left_d;
  logic [BYTE_W-1:0] txb_q, txb_d, word_q, word_d;
  logic [DW-1:0]     shr_q, shr_d;
  logic [SW-1:0]     settle_q, settle_d;
  logic              wait_q, wait_d, nak_q, nak_d;
  logic              done_d, err_d, nodev_d;
  logic              launch, l_wide;
  logic [BYTE_W-1:0] l_addr;
  logic              cmd_state, step;

  // bit command belonging to each state
  always_comb begin
    phy_cmd  = BC_STOP;
    phy_wbit = 1'b1;
    unique case (st_q)
      SQ_START, SQ_RSTART: phy_cmd = BC_START;
      SQ_TX: begin
        phy_cmd  = BC_WR;
        phy_wbit = txb_q[bitn_q];
      end
      SQ_MACK: begin
        phy_cmd  = BC_WR;
        phy_wbit = (left_q == '0);
      end
      SQ_SACK, SQ_RX: phy_cmd = BC_RD;
      default: phy_cmd = BC_STOP;
    endcase
  end

  assign cmd_state = (st_q != SQ_BOOT) && (st_q != SQ_IDLE);
  assign phy_go    = cmd_state && !wait_q && !phy_busy;
  assign step      = wait_q && phy_done;

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    bitn_d   = bitn_q;
    left_d   = left_q;
    txb_d    = txb_q;
    word_d   = word_q;
    shr_d    = shr_q;
    settle_d = settle_q;
    nak_d    = nak_q;
    done_d   = done;
    err_d    = err;
    nodev_d  = no_dev;
    wait_d   = wait_q;
    launch   = 1'b0;
    l_addr   = req_addr;
    l_wide   = req_dword;

    if (phy_go) wait_d = 1'b1;
    if (step)   wait_d = 1'b0;

    unique case (st_q)
      SQ_BOOT: begin
        if (settle_q == SW'(BOOT_SETTLE)) begin
          if (bus_ok) begin
            launch = 1'b1;
            l_addr = BOOT_ADDR;
            l_wide = 1'b1;
          end else begin
            nodev_d = 1'b1;
            st_d    = SQ_IDLE;
          end
        end else begin
          settle_d = settle_q + 1'b1;
        end
      end
      SQ_IDLE: launch = req_go;
      SQ_START, SQ_RSTART: if (step) begin
        txb_d  = {EE_DEV, (st_q == SQ_RSTART)};
        sel_d  = (st_q == SQ_RSTART) ? PH_DEVR : PH_DEVW;
        bitn_d = 3'd7;
        st_d   = SQ_TX;
      end
      SQ_TX: if (step) begin
        if (bitn_q == 3'd0) st_d = SQ_SACK;
        else                bitn_d = bitn_q - 3'd1;
      end
      SQ_SACK: if (step) begin
        bitn_d = 3'd7;
        if (phy_rbit) begin
          nak_d = 1'b1;
          st_d  = SQ_STOP;
        end else begin
          unique case (sel_q)
            PH_DEVW: begin
              txb_d = word_q;
              sel_d = PH_WORD;
              st_d  = SQ_TX;
            end
            PH_WORD: st_d = SQ_RSTART;
            default: st_d = SQ_RX;
          endcase
        end
      end
      SQ_RX: if (step) begin
        shr_d = {shr_q[DW-2:0], phy_rbit};
        if (bitn_q == 3'd0) st_d = SQ_MACK;
        else                bitn_d = bitn_q - 3'd1;
      end
      SQ_MACK: if (step) begin
        if (left_q == '0) begin
          st_d = SQ_STOP;
        end else begin
          left_d = left_q - 1'b1;
          bitn_d = 3'd7;
          st_d   = SQ_RX;
        end
      end
      SQ_STOP: if (step) begin
        st_d   = SQ_IDLE;
        done_d = 1'b1;
        err_d  = nak_q;
      end
      default: st_d = SQ_IDLE;
    endcase

    if (launch) begin
      word_d  = l_addr;
      left_d  = l_wide ? LW'(WIDE_BYTES - 1) : '0;
      shr_d   = '0;
      nak_d   = 1'b0;
      done_d  = 1'b0;
      err_d   = 1'b0;
      nodev_d = 1'b0;
      st_d    = SQ_START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_BOOT;
      sel_q    <= PH_DEVW;
      bitn_q   <= 3'd7;
      left_q   <= '0;
      txb_q    <= '0;
      word_q   <= '0;
      shr_q    <= '0;
      settle_q <= '0;
      wait_q   <= 1'b0;
      nak_q    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      no_dev   <= 1'b0;
    end else begin
      st_q     <= st_d;
      sel_q    <= sel_d;
      bitn_q   <= bitn_d;
      left_q   <= left_d;
      txb_q    <= txb_d;
      word_q   <= word_d;
      shr_q    <= shr_d;
      settle_q <= settle_d;
      wait_q   <= wait_d;
      nak_q    <= nak_d;
      done     <= done_d;
      err      <= err_d;
      no_dev   <= nodev_d;
    end
  end

  assign rd_data = shr_q;
  assign busy    = (st_q != SQ_IDLE);
endmodule

// File: rtl/eeprom_boot_reader.sv
`timescale 1ns/1ps
module eeprom_boot_reader
  import eeb_pkg::*;
#(
  parameter int         QTR_DIV     = 4,
  parameter logic [7:0] BOOT_ADDR   = 8'h00,
  parameter int         BOOT_SETTLE = 3,
  parameter int         WIDE_BYTES  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         scl_o,
  input  logic                         scl_i,
  output logic                         sda_oe,
  input  logic                         sda_i,
  input  logic [BYTE_W-1:0]            req_addr,
  input  logic                         req_dword,
  input  logic                         req_go,
  output logic [BYTE_W*WIDE_BYTES-1:0] rd_data,
  output logic                         done,
  output logic                         err,
  output logic                         no_dev,
  output logic                         busy
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sh, scl_sh, sda_sh;
  logic              rst_int_n;
  logic              tick, phy_go, phy_wbit, phy_busy, phy_done, phy_rbit;
  bitcmd_e           phy_cmd;

  // reset: asserted at once, released after SYNC_N clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sh[SYNC_N-1];

  // bus level synchronisers, cleared so an absent bus never looks present
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      scl_sh <= '0;
      sda_sh <= '0;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
    end
  end

  eeb_clkdiv #(.QTR_DIV(QTR_DIV)) u_div (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  eeb_bitphy u_phy (
    .clk(clk), .rst_n(rst_int_n), .tick(tick),
    .go(phy_go), .cmd(phy_cmd), .wbit(phy_wbit),
    .sda_in(sda_sh[SYNC_N-1]),
    .busy(phy_busy), .done(phy_done), .rbit(phy_rbit),
    .scl_o(scl_o), .sda_oe(sda_oe)
  );

  eeb_seq #(
    .BOOT_ADDR(BOOT_ADDR), .BOOT_SETTLE(BOOT_SETTLE), .WIDE_BYTES(WIDE_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .bus_ok(scl_sh[SYNC_N-1] && sda_sh[SYNC_N-1]),
    .req_addr(req_addr), .req_dword(req_dword), .req_go(req_go),
    .phy_busy(phy_busy), .phy_done(phy_done), .phy_rbit(phy_rbit),
    .phy_go(phy_go), .phy_cmd(phy_cmd), .phy_wbit(phy_wbit),
    .rd_data(rd_data), .done(done), .err(err), .no_dev(no_dev), .busy(busy)
  );
endmodule

// File: rtl/eeprom_boot_reader_chk.sv
`timescale 1ns/1ps
module eeprom_boot_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_o,
  input logic sda_oe,
  input logic req_go,
  input logic done,
  input logic err,
  input logic no_dev,
  input logic busy
);
  // R8
  scl_sda_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_o) && !$stable(sda_oe)));

  // R2
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |-> (!busy && scl_o && !sda_oe));

  // R11
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R9
  start_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_go));
endmodule

bind eeprom_boot_reader eeprom_boot_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_oe(sda_oe), .req_go(req_go),
  .done(done), .err(err), .no_dev(no_dev), .busy(busy)
);

// File: tb/eeprom_boot_reader_tb.sv
`timescale 1ns/1ps
module eeprom_boot_reader_tb;
  localparam int QD = 4;

  logic        clk;
  logic        rst_n;
  logic        scl_o, sda_oe;
  logic [7:0]  req_addr;
  logic        req_dword, req_go;
  logic [31:0] rd_data;
  logic        done, err, no_dev, busy;
  logic        slv_low, scl_hold;
  wire         sda_line = !(sda_oe || slv_low);
  wire         scl_line = scl_o && !scl_hold;

  eeprom_boot_reader u_dut (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .scl_i(scl_line),
    .sda_oe(sda_oe), .sda_i(sda_line),
    .req_addr(req_addr), .req_dword(req_dword), .req_go(req_go),
    .rd_data(rd_data), .done(done), .err(err), .no_dev(no_dev), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // EEPROM model: contents scrambled from the address
  function automatic logic [7:0] ee_mem(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'hC3;
  endfunction

  int         sl_mode;   // 0 idle, 1 device byte, 2 word byte, 3 sending, 4 wait restart
  int         sl_bit;
  int         nack_at;   // 0 none, 1 write device byte, 2 word byte, 3 read device byte
  logic [7:0] sl_sh, sl_ptr;
  logic       sl_ack, sl_mack;
  int         n_start, n_stop, n_mack0, n_mack1;
  logic [15:0] dev_log;
  logic [7:0]  word_seen;

  initial begin
    slv_low = 1'b0; sl_mode = 0; sl_bit = 0; nack_at = 0;
    sl_sh = '0; sl_ptr = '0; sl_ack = 1'b0; sl_mack = 1'b1;
  end

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    n_start++; sl_mode = 1; sl_bit = -1; slv_low = 1'b0;
  end

  always @(posedge sda_line) if (scl_line === 1'b1) begin
    n_stop++; sl_mode = 0; slv_low = 1'b0;
  end

  always @(posedge scl_line) begin
    if ((sl_mode == 1 || sl_mode == 2) && sl_bit >= 0 && sl_bit < 8) sl_sh = {sl_sh[6:0], sda_line};
    if (sl_mode == 3 && sl_bit == 8) sl_mack = sda_line;
  end

  always @(negedge scl_line) begin
    if (sl_mode == 1 || sl_mode == 2) begin
      sl_bit++;
      if (sl_bit == 8) begin
        if (sl_mode == 1) begin
          dev_log = {dev_log[7:0], sl_sh};
          sl_ack = (sl_sh[7:1] == 7'h50) && !(nack_at == 1 && !sl_sh[0]) && !(nack_at == 3 && sl_sh[0]);
        end else begin
          word_seen = sl_sh;
          sl_ptr = sl_sh;
          sl_ack = (nack_at != 2);
        end
        slv_low = sl_ack;
      end else if (sl_bit == 9) begin
        slv_low = 1'b0;
        sl_bit = 0;
        if (!sl_ack) sl_mode = 0;
        else if (sl_mode == 1 && sl_sh[0]) begin
          sl_mode = 3; sl_sh = ee_mem(sl_ptr); slv_low = !sl_sh[7];
        end else if (sl_mode == 1) sl_mode = 2;
        else sl_mode = 4;
      end
    end else if (sl_mode == 3) begin
      sl_bit++;
      if (sl_bit <= 7) slv_low = !sl_sh[7 - sl_bit];
      else if (sl_bit == 8) slv_low = 1'b0;
      else begin
        if (sl_mack == 1'b0) begin
          n_mack0++; sl_ptr = sl_ptr + 8'd1; sl_sh = ee_mem(sl_ptr);
          sl_bit = 0; slv_low = !sl_sh[7];
        end else begin
          n_mack1++; sl_mode = 0;
        end
      end
    end
  end

  // bus timing monitors
  int   hi_cnt, hi_good, hi_bad, r8_bad;
  logic skip_first, p_scl, p_oe;
  initial begin hi_cnt = 0; hi_good = 0; hi_bad = 0; r8_bad = 0; skip_first = 1'b1; p_scl = 1'b1; p_oe = 1'b0; end
  always @(posedge clk) if (rst_n) begin
    if (scl_o !== p_scl && sda_oe !== p_oe) r8_bad++;
    p_scl = scl_o; p_oe = sda_oe;
    if (!busy) begin
      hi_cnt = 0; skip_first = 1'b1;
    end else if (scl_o) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (skip_first) skip_first = 1'b0;
      else if (hi_cnt == 2 * QD) hi_good++;
      else hi_bad++;
      hi_cnt = 0;
    end
  end

  task automatic clear_mon();
    n_start = 0; n_stop = 0; n_mack0 = 0; n_mack1 = 0;
    dev_log = '0; word_seen = '0; hi_good = 0; hi_bad = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [7:0] a, input logic wide);
    if (wide) return {ee_mem(a), ee_mem(a + 8'd1), ee_mem(a + 8'd2), ee_mem(a + 8'd3)};
    return {24'h0, ee_mem(a)};
  endfunction

  task automatic check_ok_txn(input logic [7:0] a, input logic wide, input string tag);
    chk(err == 1'b0, {tag, " R7 no error"}, 32'(err), 32'd0);
    chk(rd_data == exp_data(a, wide), {tag, wide ? " R5 dword data" : " R4 byte data"}, rd_data, exp_data(a, wide));
    chk(dev_log == 16'hA0A1, {tag, " R3 device bytes"}, 32'(dev_log), 32'h0000A0A1);
    chk(word_seen == a, {tag, " R3 word address"}, 32'(word_seen), 32'(a));
    chk(n_start == 2, {tag, " R3 start count"}, 32'(n_start), 32'd2);
    chk(n_mack0 == (wide ? 3 : 0) && n_mack1 == 1, {tag, " R6 master ack pattern"},
        32'(n_mack0 * 16 + n_mack1), wide ? 32'h31 : 32'h01);
    chk(n_stop == 1, {tag, " R6 stop"}, 32'(n_stop), 32'd1);
    chk(hi_good > 0 && hi_bad == 0, {tag, " R10 scl high width"}, 32'(hi_bad), 32'd0);
  endtask

  task automatic run_txn(input logic [7:0] a, input logic wide, input int nk, input logic exp_err);
    bit ok;
    string tag;
    tag = $sformatf("txn a=%h w=%0d nk=%0d", a, wide, nk);
    clear_mon();
    nack_at = nk;
    @(negedge clk);
    req_addr = a; req_dword = wide; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    chk(busy && !done && !err, {tag, " R11 busy and flags cleared"}, {29'h0, busy, done, err}, 32'h4);
    wait_done(ok);
    chk(ok, {tag, " R11 done reached"}, 32'(ok), 32'd1);
    if (exp_err) begin
      chk(err == 1'b1, {tag, " R7 error flag"}, 32'(err), 32'd1);
      chk(n_stop == 1, {tag, " R7 stop after nack"}, 32'(n_stop), 32'd1);
    end else begin
      check_ok_txn(a, wide, tag);
    end
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && err == exp_err, {tag, " R11 flags held"}, {30'h0, done, err}, {30'h0, 1'b1, exp_err});
    nack_at = 0;
  endtask

  // {word address, wide, nack slot, expected error}
  localparam logic [11:0] VEC [7] = '{
    {8'h10, 1'b0, 2'd0, 1'b0},
    {8'hFE, 1'b1, 2'd0, 1'b0},
    {8'h7C, 1'b1, 2'd0, 1'b0},
    {8'h33, 1'b0, 2'd1, 1'b1},
    {8'h44, 1'b1, 2'd2, 1'b1},
    {8'h58, 1'b1, 2'd3, 1'b1},
    {8'hC9, 1'b0, 2'd0, 1'b0}
  };

  initial begin
    bit ok;
    rst_n = 1'b0; scl_hold = 1'b0;
    req_addr = '0; req_dword = 1'b0; req_go = 1'b0;
    repeat (5) @(negedge clk);
    chk(scl_o && !sda_oe && !done && !err && !no_dev, "R11 reset state",
        {27'h0, scl_o, sda_oe, done, err, no_dev}, 32'h10);
    clear_mon();
    rst_n = 1'b1;

    // R1 automatic boot load
    wait_done(ok);
    chk(ok, "R1 boot load finished", 32'(ok), 32'd1);
    chk(no_dev == 1'b0, "R1 device present", 32'(no_dev), 32'd0);
    chk(rd_data == exp_data(8'h00, 1'b1), "R1 boot data", rd_data, exp_data(8'h00, 1'b1));
    check_ok_txn(8'h00, 1'b1, "boot");

    foreach (VEC[i]) run_txn(VEC[i][11:4], VEC[i][3], int'(VEC[i][2:1]), VEC[i][0]);

    // R9 request during a transfer is ignored
    clear_mon();
    @(negedge clk);
    req_addr = 8'h20; req_dword = 1'b0; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    repeat (60) @(negedge clk);
    req_addr = 8'h99; req_dword = 1'b1; req_go = 1'b1;
    @(negedge clk);
    req_go = 1'b0;
    wait_done(ok);
    chk(rd_data == exp_data(8'h20, 1'b0), "R9 first request result kept", rd_data, exp_data(8'h20, 1'b0));
    chk(word_seen == 8'h20, "R9 word address of first request", 32'(word_seen), 32'h20);
    repeat (60) @(negedge clk);
    chk(!busy && done && n_start == 2, "R9 no second transfer", {30'h0, busy, done}, 32'h1);

    chk(r8_bad == 0, "R8 scl and sda never switch together", 32'(r8_bad), 32'd0);

    // R2 bus absent at reset release
    scl_hold = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon();
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    chk(no_dev && !busy && !done, "R2 absent bus reported", {29'h0, no_dev, busy, done}, 32'h4);
    chk(scl_o && !sda_oe && n_start == 0, "R2 lines left idle", {30'h0, scl_o, sda_oe}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule